// File: doc/BRIEF.md
# Block Transfer Byte Packing Engine

This block sits between a byte-wide card data port and a 16-bit word FIFO. On a receive transfer it takes bytes from the card and packs each pair into one FIFO word. On a transmit transfer it takes words from the FIFO and splits each one into two bytes for the card. The FIFO storage is part of the block. A CPU-side word port pushes transmit data into the FIFO and pops receive data from it.

A transfer is shaped by two programmed values: the bytes per block and the number of blocks. Each register holds the written field plus one. Two down-counters follow the transfer byte by byte, and the block shows their live values. A block of odd length ends in a half-filled word. When the last byte of the last block moves, the counters reload, the block goes idle and a sticky done flag rises.

Receive waits for the FIFO to drain below a programmable almost-full level before it starts a new word. Transmit waits while the FIFO is empty. The card port moves at most one byte per clock, on a valid/ready handshake.

Top module: `blk_pack_engine`

## Requirements
- R1: A write with `cfg_wr`=1 and `cfg_sel`=0 sets the block length to `cfg_wdata`+1 and loads the byte counter with that value.
- R2: A write with `cfg_wr`=1 and `cfg_sel`=1 sets the block count to `cfg_wdata`+1, loads the block counter with it, and reloads the byte counter with the block length. During a write cycle the card port moves no byte.
- R3: `len_cnt_o` and `blk_cnt_o` show the live down-counters. The byte counter drops by one for each byte moved, and the programmed values are not shown.
- R4: On receive (`dir_rx`=1 when `start` is pulsed), the first byte of a pair goes to FIFO word bits [7:0] and the second to bits [15:8]. The word is written when its second byte arrives.
- R5: When a block has odd length, its last byte ends the word. On receive that word is written with bits [15:8] zero. On transmit the word is popped after its low byte alone.
- R6: On transmit (`dir_rx`=0 when `start` is pulsed), the head word's bits [7:0] go out first, then bits [15:8]. The word is popped after its high byte.
- R7: On receive, `crd_rx_ready` is low at the start of a new word while `fifo_level` exceeds `afull_lvl`. The counters then hold.
- R8: On transmit, `crd_tx_valid` is low while the FIFO is empty.
- R9: When the byte counter moves its last byte of a block, it reloads to the block length, the block counter drops by one, and packing starts a fresh word.
- R10: When the last byte of the last block moves, both counters reload to the programmed values, `busy_o` falls and `done_o` rises. `done_o` stays high until `done_clr` is pulsed.
- R11: `cpu_push` has no effect during a receive transfer or when the FIFO is full. `cpu_pop` has no effect during a transmit transfer or when the FIFO is empty. The FIFO never holds more than DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects block length, 1 selects block count |
| cfg_wdata | input | CNT_W | Value field; register stores value+1 |
| len_cnt_o | output | CNT_W+1 | Live byte-within-block counter |
| blk_cnt_o | output | CNT_W+1 | Live remaining-block counter |
| start | input | 1 | Begin a transfer (ignored while busy) |
| dir_rx | input | 1 | Direction at start: 1 card to FIFO, 0 FIFO to card |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky transfer-done flag |
| done_clr | input | 1 | Clears done flag |
| afull_lvl | input | log2(DEPTH) | Almost-full level for receive stalls |
| cpu_push | input | 1 | Push a word into the FIFO |
| cpu_wdata | input | 16 | Word to push |
| cpu_pop | input | 1 | Pop the head word |
| cpu_rdata | output | 16 | FIFO head word |
| fifo_level | output | log2(DEPTH)+1 | Words held in the FIFO |
| crd_rx_valid | input | 1 | Card byte available |
| crd_rx_data | input | 8 | Card byte |
| crd_rx_ready | output | 1 | Block accepts card byte |
| crd_tx_valid | output | 1 | Byte offered to card |
| crd_tx_data | output | 8 | Byte to card |
| crd_tx_ready | input | 1 | Card takes byte |

## Verification
The bench builds the block with DEPTH=8 and CNT_W=11. With the shallow FIFO, filling it to the brim, the full-push drop and the almost-full stall all occur within a few words. The full 11-bit length field is kept, so the bench still drives the real counter widths while it uses short blocks of even and odd length.

// File: rtl/blk_pack_engine.sv
module blk_pack_engine #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 11,
  localparam int LW = $clog2(DEPTH),
  localparam int CW = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic [CW-1:0] len_cnt_o,
  output logic [CW-1:0] blk_cnt_o,
  input  logic          start,
  input  logic          dir_rx,
  output logic          busy_o,
  output logic          done_o,
  input  logic          done_clr,
  input  logic [LW-1:0] afull_lvl,
  input  logic          cpu_push,
  input  logic [15:0]   cpu_wdata,
  input  logic          cpu_pop,
  output logic [15:0]   cpu_rdata,
  output logic [LW:0]   fifo_level,
  input  logic          crd_rx_valid,
  input  logic [7:0]    crd_rx_data,
  output logic          crd_rx_ready,
  output logic          crd_tx_valid,
  output logic [7:0]    crd_tx_data,
  input  logic          crd_tx_ready
);

  logic [15:0]   mem [DEPTH];
  logic [LW-1:0] rd_ptr, wr_ptr;
  logic [LW:0]   level;
  logic [CW-1:0] len_reg, blk_reg, len_cnt, blk_cnt;
  logic          busy, rx_mode, half, done;
  logic [7:0]    lo_byte;

  wire [CW-1:0] cfg_val   = {1'b0, cfg_wdata} + CW'(1);
  wire          last_byte = (len_cnt == CW'(1));
  wire          last_blk  = (blk_cnt == CW'(1));
  wire          fifo_full = (level == (LW+1)'(DEPTH));
  wire          fifo_empty = (level == '0);

  assign crd_rx_ready = busy & rx_mode & ~cfg_wr & (half | (level <= {1'b0, afull_lvl}));
  assign crd_tx_valid = busy & ~rx_mode & ~cfg_wr & ~fifo_empty;
  assign crd_tx_data  = half ? mem[rd_ptr][15:8] : mem[rd_ptr][7:0];

  wire rx_go   = crd_rx_valid & crd_rx_ready;
  wire tx_go   = crd_tx_valid & crd_tx_ready;
  wire byte_go = rx_go | tx_go;
  wire xfer_end = byte_go & last_byte & last_blk;

  wire        eng_push = rx_go & (half | last_byte);
  wire        eng_pop  = tx_go & (half | last_byte);
  wire [15:0] eng_word = half ? {crd_rx_data, lo_byte} : {8'h00, crd_rx_data};
  wire        cpu_push_ok = cpu_push & ~(busy & rx_mode) & ~fifo_full;
  wire        cpu_pop_ok  = cpu_pop & ~(busy & ~rx_mode) & ~fifo_empty;
  wire        push = eng_push | cpu_push_ok;
  wire        pop  = eng_pop | cpu_pop_ok;

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= eng_push ? eng_word : cpu_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + LW'(1);
      if (pop)  rd_ptr <= rd_ptr + LW'(1);
      level <= level + (LW+1)'(push) - (LW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_reg <= CW'(1);
      blk_reg <= CW'(1);
      len_cnt <= CW'(1);
      blk_cnt <= CW'(1);
    end else if (cfg_wr) begin
      if (!cfg_sel) begin
        len_reg <= cfg_val;
        len_cnt <= cfg_val;
      end else begin
        blk_reg <= cfg_val;
        blk_cnt <= cfg_val;
        len_cnt <= len_reg;
      end
    end else if (byte_go) begin
      if (last_byte) begin
        len_cnt <= len_reg;
        blk_cnt <= last_blk ? blk_reg : blk_cnt - CW'(1);
      end else begin
        len_cnt <= len_cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rx_mode <= 1'b0;
      half    <= 1'b0;
      done    <= 1'b0;
      lo_byte <= '0;
    end else begin
      if (start && !busy) begin
        busy    <= 1'b1;
        rx_mode <= dir_rx;
        half    <= 1'b0;
      end else if (byte_go) begin
        half <= ~half & ~last_byte;
        if (xfer_end) busy <= 1'b0;
      end
      if (rx_go && !half) lo_byte <= crd_rx_data;
      if (xfer_end) done <= 1'b1;
      else if (done_clr) done <= 1'b0;
    end
  end

  assign len_cnt_o  = len_cnt;
  assign blk_cnt_o  = blk_cnt;
  assign busy_o     = busy;
  assign done_o     = done;
  assign cpu_rdata  = mem[rd_ptr];
  assign fifo_level = level;

  // R10
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $fell(busy_o));

  // R10
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (len_cnt == len_reg && blk_cnt == blk_reg));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_cnt != '0 && len_cnt <= len_reg && blk_cnt != '0 && blk_cnt <= blk_reg));

  // R7
  rx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_mode && !crd_rx_ready && !cfg_wr) |=> $stable(len_cnt));

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= (LW+1)'(DEPTH));

endmodule

// File: tb/sim_blk_pack_engine.sv
`timescale 1ns/1ps
module sim_blk_pack_engine;
  localparam int DEPTH = 8;
  localparam int CNT_W = 11;
  localparam int LW = 3;
  localparam int CW = 12;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [CNT_W-1:0] cfg_wdata = '0;
  logic [CW-1:0] len_cnt_o, blk_cnt_o;
  logic start = 0, dir_rx = 0, busy_o, done_o, done_clr = 0;
  logic [LW-1:0] afull_lvl = 3'd7;
  logic cpu_push = 0, cpu_pop = 0;
  logic [15:0] cpu_wdata = '0, cpu_rdata;
  logic [LW:0] fifo_level;
  logic crd_rx_valid = 0, crd_rx_ready, crd_tx_valid, crd_tx_ready = 0;
  logic [7:0] crd_rx_data = '0, crd_tx_data;

  int checks = 0, fails = 0;

  blk_pack_engine #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .len_cnt_o(len_cnt_o), .blk_cnt_o(blk_cnt_o), .start(start), .dir_rx(dir_rx),
    .busy_o(busy_o), .done_o(done_o), .done_clr(done_clr), .afull_lvl(afull_lvl),
    .cpu_push(cpu_push), .cpu_wdata(cpu_wdata), .cpu_pop(cpu_pop), .cpu_rdata(cpu_rdata),
    .fifo_level(fifo_level), .crd_rx_valid(crd_rx_valid), .crd_rx_data(crd_rx_data),
    .crd_rx_ready(crd_rx_ready), .crd_tx_valid(crd_tx_valid), .crd_tx_data(crd_tx_data),
    .crd_tx_ready(crd_tx_ready));

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input bit sel, input int val);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = CNT_W'(val);
    tick();
    cfg_wr = 0;
  endtask

  task automatic go(input bit rx);
    dir_rx = rx; start = 1;
    tick();
    start = 0;
  endtask

  task automatic push_w(input logic [15:0] w);
    cpu_push = 1; cpu_wdata = w;
    tick();
    cpu_push = 0;
  endtask

  task automatic pop_w(input string req, input int exp);
    chk(req, cpu_rdata, exp);
    cpu_pop = 1;
    tick();
    cpu_pop = 0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    crd_rx_valid = 1; crd_rx_data = b;
    for (int i = 0; i < 50; i++) begin
      if (crd_rx_ready) break;
      tick();
    end
    tick();
    crd_rx_valid = 0;
  endtask

  task automatic recv_tx(input string req, input int exp);
    crd_tx_ready = 1;
    for (int i = 0; i < 50; i++) begin
      if (crd_tx_valid) break;
      tick();
    end
    chk(req, crd_tx_data, exp);
    tick();
    crd_tx_ready = 0;
  endtask

  task automatic t_reset();
    chk("R3 reset len", len_cnt_o, 1);
    chk("R3 reset blk", blk_cnt_o, 1);
    chk("R10 reset busy", busy_o, 0);
    chk("R10 reset done", done_o, 0);
    chk("R11 reset level", fifo_level, 0);
  endtask

  task automatic t_cfg();
    cfg(0, 5);
    chk("R1 len field", len_cnt_o, 6);
    cfg(1, 2);
    chk("R2 blk field", blk_cnt_o, 3);
    chk("R2 len reload", len_cnt_o, 6);
  endtask

  task automatic t_rx_even();
    cfg(0, 3); cfg(1, 1);
    go(1);
    chk("R10 busy", busy_o, 1);
    push_w(16'hDEAD);
    chk("R11 push ignored in rx", fifo_level, 0);
    send_rx(8'h11);
    chk("R3 live len", len_cnt_o, 3);
    chk("R4 no word after one byte", fifo_level, 0);
    send_rx(8'h12); send_rx(8'h13); send_rx(8'h14);
    chk("R9 len reload", len_cnt_o, 4);
    chk("R9 blk dec", blk_cnt_o, 1);
    send_rx(8'h15); send_rx(8'h16); send_rx(8'h17); send_rx(8'h18);
    chk("R10 busy fell", busy_o, 0);
    chk("R10 done set", done_o, 1);
    chk("R10 len reload", len_cnt_o, 4);
    chk("R10 blk reload", blk_cnt_o, 2);
    chk("R4 level", fifo_level, 4);
    pop_w("R4 word0", 16'h1211);
    pop_w("R4 word1", 16'h1413);
    pop_w("R4 word2", 16'h1615);
    pop_w("R4 word3", 16'h1817);
    done_clr = 1; tick(); done_clr = 0;
    chk("R10 done clear", done_o, 0);
  endtask

  task automatic t_rx_odd();
    cfg(0, 2); cfg(1, 1);
    go(1);
    send_rx(8'hA1); send_rx(8'hA2); send_rx(8'hA3);
    chk("R5 odd block word count", fifo_level, 2);
    send_rx(8'hA4); send_rx(8'hA5); send_rx(8'hA6);
    chk("R10 odd done", done_o, 1);
    pop_w("R5 word0", 16'hA2A1);
    pop_w("R5 half word", 16'h00A3);
    pop_w("R9 fresh word", 16'hA5A4);
    pop_w("R5 half word 2", 16'h00A6);
    done_clr = 1; tick(); done_clr = 0;
  endtask

  task automatic t_rx_stall();
    afull_lvl = 3'd1;
    cfg(0, 7); cfg(1, 0);
    go(1);
    send_rx(8'h31); send_rx(8'h32); send_rx(8'h33); send_rx(8'h34);
    crd_rx_valid = 1; crd_rx_data = 8'h55;
    chk("R7 ready low", crd_rx_ready, 0);
    tick(); tick(); tick();
    chk("R7 counter held", len_cnt_o, 4);
    pop_w("R7 pop", 16'h3231);
    chk("R7 ready back", crd_rx_ready, 1);
    send_rx(8'h55);
    afull_lvl = 3'd7;
    send_rx(8'h66); send_rx(8'h77); send_rx(8'h88);
    chk("R10 stall done", done_o, 1);
    pop_w("R4 stall word1", 16'h3433);
    pop_w("R4 stall word2", 16'h6655);
    pop_w("R4 stall word3", 16'h8877);
    done_clr = 1; tick(); done_clr = 0;
  endtask

  task automatic t_tx();
    cfg(0, 4); cfg(1, 0);
    go(0);
    chk("R8 empty valid low", crd_tx_valid, 0);
    tick(); tick(); tick();
    chk("R8 still low", crd_tx_valid, 0);
    push_w(16'h2B1A);
    chk("R8 valid with data", crd_tx_valid, 1);
    push_w(16'h4D3C); push_w(16'h006E);
    cpu_pop = 1; tick(); cpu_pop = 0;
    chk("R11 pop ignored in tx", fifo_level, 3);
    recv_tx("R6 byte0 low", 8'h1A);
    chk("R6 no pop after low byte", fifo_level, 3);
    recv_tx("R6 byte1 high", 8'h2B);
    chk("R6 pop after high byte", fifo_level, 2);
    recv_tx("R6 byte2", 8'h3C);
    recv_tx("R6 byte3", 8'h4D);
    recv_tx("R5 tx last low", 8'h6E);
    chk("R5 tx half word popped", fifo_level, 0);
    chk("R10 tx done", done_o, 1);
    chk("R10 tx idle", busy_o, 0);
    done_clr = 1; tick(); done_clr = 0;
  endtask

  task automatic t_full();
    for (int i = 0; i < 9; i++) push_w(16'(16'h0100 + i));
    chk("R11 full drop", fifo_level, 8);
    for (int i = 0; i < 8; i++) pop_w("R11 order", 16'h0100 + i);
    cpu_pop = 1; tick(); cpu_pop = 0;
    chk("R11 empty pop", fifo_level, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_cfg();
    t_rx_even();
    t_rx_odd();
    t_rx_stall();
    t_tx();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule